// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a NOR-style flash device. It watches bus-write cycles (a one-cycle write strobe with an address and a command byte) and keeps track of which source the read path should present: the memory array, the identification words, the query table or the status byte. It decodes the two-cycle sequences that program a word, erase a block and load the burst configuration register. It also handles suspending and resuming a running operation.

Program and erase operations run on an internal stub engine. The stub models the busy time with a down-counter and models the suspend latency with a second counter. The block assembles the status byte from the state of the stub and from sticky error flags. A per-block protect vector blocks program and erase requests aimed at locked blocks. The start, operation-kind and suspend strobes are exported so that a neighbouring array model can follow the operations.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, rdSel is 0 (array), statusByte is 80h and cfgOut is 0000h.
- R2: Each of the following writes selects a read source, and that source persists until another accepted command changes it. The encoding is 0 array, 1 identification, 2 query, 3 status. FFh selects array, 90h selects identification, 98h selects query and 70h selects status. Writes of B0h or D0h while no operation is started or paused leave rdSel and statusByte unchanged.
- R3: In identification mode, idWord is 0020h when idSel is 0. When idSel is 1, idWord is the device code: 8836h with TOP_BOOT=1, or 8835h otherwise.
- R4: A write of 40h followed by any write to an unprotected block starts a program. opStart pulses with opErase low during the second write, and rdSel becomes 3. statusByte[7] then reads 0 for exactly PROG_CYCLES cycles before it returns to 1.
- R5: A write of 20h followed by D0h at an address in an unprotected block starts an erase. opStart and opErase both pulse, and statusByte[7] reads 0 for ERASE_CYCLES cycles. If the second write is any other byte, nothing starts, statusByte bits 5 and 4 are set, and rdSel becomes 3.
- R6: The target block is selected by the top BLK_W address bits and indexes protBlk. If a program or erase is aimed at a protected block, nothing starts. statusByte bit 1 is set, together with bit 4 for a program or bit 5 for an erase.
- R7: While an operation runs or is pausing, statusByte[7] is 0. Only B0h and 70h are acted on; every other write is ignored, and this includes writes that would begin a two-cycle sequence.
- R8: A B0h write while an operation runs pulses opSuspend. SUSP_CYCLES cycles later, statusByte[7] rises together with bit 6 (erase paused) or bit 2 (program paused).
- R9: While paused, FFh, 90h, 98h, 70h and 50h are accepted. A D0h write resumes the operation: the paused bit clears, bit 7 drops, rdSel becomes 3, and the remaining busy time is the time that was left at the suspend.
- R10: A write of 50h clears statusByte bits 5, 4 and 1 and leaves rdSel unchanged.
- R11: A write of 60h followed by 03h loads cfgOut from wrAddr[15:0] and sets rdSel to 0. If the second byte is anything else, cfgOut is left unchanged and rdSel is still set to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus-write strobe, one cycle per write |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Command or data byte |
| protBlk | input | 2**BLK_W | Per-block protect flags |
| idSel | input | 1 | Picks the manufacturer (0) or device (1) identification word |
| rdSel | output | 2 | Read-source select |
| statusByte | output | 8 | Status register |
| idWord | output | 16 | Identification word |
| cfgOut | output | 16 | Burst configuration register |
| opStart | output | 1 | Operation start strobe |
| opErase | output | 1 | Started operation is an erase |
| opSuspend | output | 1 | Suspend request strobe |

## Verification
The bench counts the exact busy window of a program, an erase, and an erase that receives writes while busy. An off-by-one in the stub counter, or a busy engine that still accepts commands, changes the measured window. Suspend is checked at the exact cycle the paused bit rises, then again after resume. A design that kept counting during the pause, or lost the remaining time, would finish early. Bad erase confirms, protected targets and a configuration write with the wrong second byte are each driven. A decoder that started the engine, skipped the error bits or loaded the register would show a wrong status byte, a spurious opStart or a changed cfgOut.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_QUERY   = 8'h98;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_PROGRAM = 8'h40;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_CFGSET  = 8'h60;
  localparam logic [7:0] CMD_CFGCONF = 8'h03;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_IDENT  = 2'd1,
    SRC_QUERY  = 2'd2,
    SRC_STATUS = 2'd3
  } rdSrc_t;

  typedef enum logic [1:0] {
    PEND_NONE,
    PEND_PROG,
    PEND_ERASE,
    PEND_CFG
  } pend_t;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_RUN,
    ENG_HALT,
    ENG_PAUSE
  } engState_t;

  typedef struct packed {
    logic start;
    logic erase;
    logic suspend;
    logic resume;
    logic clrErr;
    logic setProgErr;
    logic setEraseErr;
    logic setProtErr;
    logic loadCfg;
  } ctlStrobe_t;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BLK_W  = 5,
  localparam int NUM_BLK = 2 ** BLK_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [7:0]         wrData,
  input  logic [NUM_BLK-1:0] protBlk,
  input  logic               engRunning,
  input  logic               engHalting,
  input  logic               engPaused,
  output rdSrc_t             rdSrc,
  output ctlStrobe_t         strb
);

  pend_t  pend, pendNext;
  rdSrc_t srcNext;
  logic   blkLocked;
  logic   engBusy;

  assign blkLocked = protBlk[wrAddr[ADDR_W-1 -: BLK_W]];
  assign engBusy   = engRunning | engHalting;

  always_comb begin
    strb     = '0;
    srcNext  = rdSrc;
    pendNext = pend;
    if (wrEn) begin
      pendNext = PEND_NONE;
      if (engBusy) begin
        if (wrData == CMD_STATUS) srcNext = SRC_STATUS;
        if (wrData == CMD_SUSPEND && engRunning) strb.suspend = 1'b1;
      end else begin
        unique case (pend)
          PEND_PROG: begin
            srcNext = SRC_STATUS;
            if (blkLocked) begin
              strb.setProtErr = 1'b1;
              strb.setProgErr = 1'b1;
            end else begin
              strb.start = 1'b1;
            end
          end
          PEND_ERASE: begin
            srcNext = SRC_STATUS;
            if (wrData != CMD_CONFIRM) begin
              strb.setEraseErr = 1'b1;
              strb.setProgErr  = 1'b1;
            end else if (blkLocked) begin
              strb.setProtErr  = 1'b1;
              strb.setEraseErr = 1'b1;
            end else begin
              strb.start = 1'b1;
              strb.erase = 1'b1;
            end
          end
          PEND_CFG: begin
            srcNext = SRC_ARRAY;
            if (wrData == CMD_CFGCONF) strb.loadCfg = 1'b1;
          end
          default: begin
            unique case (wrData)
              CMD_ARRAY:   srcNext = SRC_ARRAY;
              CMD_IDENT:   srcNext = SRC_IDENT;
              CMD_QUERY:   srcNext = SRC_QUERY;
              CMD_STATUS:  srcNext = SRC_STATUS;
              CMD_CLEAR:   strb.clrErr = 1'b1;
              CMD_PROGRAM: if (!engPaused) pendNext = PEND_PROG;
              CMD_ERASE:   if (!engPaused) pendNext = PEND_ERASE;
              CMD_CFGSET:  if (!engPaused) pendNext = PEND_CFG;
              CMD_CONFIRM: if (engPaused) begin
                strb.resume = 1'b1;
                srcNext     = SRC_STATUS;
              end
              default: ;
            endcase
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdSrc <= SRC_ARRAY;
      pend  <= PEND_NONE;
    end else begin
      rdSrc <= srcNext;
      pend  <= pendNext;
    end
  end

endmodule

// File: rtl/flash_cmd_datapath.sv
module flash_cmd_datapath
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int CFG_W        = 16,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 20,
  parameter int SUSP_CYCLES  = 3,
  parameter bit TOP_BOOT     = 1'b1,
  localparam int MAX_CYC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES,
  localparam int CNT_W    = $clog2(MAX_CYC + 1),
  localparam int SCNT_W   = $clog2(SUSP_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              idSel,
  output logic              engRunning,
  output logic              engHalting,
  output logic              engPaused,
  output logic [7:0]        statusByte,
  output logic [15:0]       idWord,
  output logic [CFG_W-1:0]  cfgOut
);

  localparam logic [15:0] MFR_CODE = 16'h0020;
  localparam logic [15:0] DEV_CODE = TOP_BOOT ? 16'h8836 : 16'h8835;

  engState_t         engSt;
  logic [CNT_W-1:0]  remain;
  logic [SCNT_W-1:0] haltCnt;
  logic              kindErase;
  logic              progErr, eraseErr, protErr;
  logic              engReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      engSt     <= ENG_IDLE;
      remain    <= '0;
      haltCnt   <= '0;
      kindErase <= 1'b0;
    end else begin
      unique case (engSt)
        ENG_IDLE: if (strb.start) begin
          engSt     <= ENG_RUN;
          kindErase <= strb.erase;
          remain    <= strb.erase ? CNT_W'(ERASE_CYCLES) : CNT_W'(PROG_CYCLES);
        end
        ENG_RUN: begin
          if (strb.suspend) begin
            engSt   <= ENG_HALT;
            haltCnt <= SCNT_W'(SUSP_CYCLES);
          end else if (remain == CNT_W'(1)) begin
            engSt  <= ENG_IDLE;
            remain <= '0;
          end else begin
            remain <= remain - CNT_W'(1);
          end
        end
        ENG_HALT: begin
          if (haltCnt == SCNT_W'(1)) engSt <= ENG_PAUSE;
          else haltCnt <= haltCnt - SCNT_W'(1);
        end
        default: if (strb.resume) engSt <= ENG_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progErr  <= 1'b0;
      eraseErr <= 1'b0;
      protErr  <= 1'b0;
      cfgOut   <= '0;
    end else begin
      if (strb.clrErr) begin
        progErr  <= 1'b0;
        eraseErr <= 1'b0;
        protErr  <= 1'b0;
      end else begin
        if (strb.setProgErr)  progErr  <= 1'b1;
        if (strb.setEraseErr) eraseErr <= 1'b1;
        if (strb.setProtErr)  protErr  <= 1'b1;
      end
      if (strb.loadCfg) cfgOut <= wrAddr[CFG_W-1:0];
    end
  end

  assign engRunning = (engSt == ENG_RUN);
  assign engHalting = (engSt == ENG_HALT);
  assign engPaused  = (engSt == ENG_PAUSE);
  assign engReady   = (engSt == ENG_IDLE) || engPaused;

  assign statusByte = {engReady, engPaused & kindErase, eraseErr, progErr,
                       1'b0, engPaused & ~kindErase, protErr, 1'b0};
  assign idWord     = idSel ? DEV_CODE : MFR_CODE;

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int BLK_W        = 5,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 20,
  parameter int SUSP_CYCLES  = 3,
  parameter bit TOP_BOOT     = 1'b1,
  localparam int NUM_BLK = 2 ** BLK_W,
  localparam int CFG_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [7:0]         wrData,
  input  logic [NUM_BLK-1:0] protBlk,
  input  logic               idSel,
  output logic [1:0]         rdSel,
  output logic [7:0]         statusByte,
  output logic [15:0]        idWord,
  output logic [CFG_W-1:0]   cfgOut,
  output logic               opStart,
  output logic               opErase,
  output logic               opSuspend
);

  ctlStrobe_t strb;
  rdSrc_t     rdSrc;
  logic       engRunning, engHalting, engPaused;

  flash_cmd_decode #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_decode (
    .clk, .rstN, .wrEn, .wrAddr, .wrData, .protBlk,
    .engRunning, .engHalting, .engPaused, .rdSrc, .strb
  );

  flash_cmd_datapath #(
    .ADDR_W(ADDR_W), .CFG_W(CFG_W), .PROG_CYCLES(PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES), .SUSP_CYCLES(SUSP_CYCLES), .TOP_BOOT(TOP_BOOT)
  ) u_datapath (
    .clk, .rstN, .strb, .wrAddr, .idSel,
    .engRunning, .engHalting, .engPaused, .statusByte, .idWord, .cfgOut
  );

  assign rdSel     = rdSrc;
  assign opStart   = strb.start;
  assign opErase   = strb.erase;
  assign opSuspend = strb.suspend;

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [1:0]  rdSel,
  input logic [7:0]  statusByte,
  input logic [15:0] cfgOut,
  input logic        opStart,
  input logic        opSuspend
);

  // R4: a started operation drops the ready bit on the next cycle
  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    opStart |=> !statusByte[7]);

  // R7: no start is issued while the engine is busy
  p_no_start_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    opStart |-> statusByte[7]);

  // R8: a suspend request only happens while busy
  p_suspend_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    opSuspend |-> !statusByte[7]);

  // R9: at most one paused flag, and only when ready
  p_paused_flags_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[6] || statusByte[2]) |-> (statusByte[7] && $onehot0({statusByte[6], statusByte[2]})));

  // R2: read source changes only after a write
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdSel));

  // R11: configuration register changes only after a write
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(cfgOut));

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (.*);

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_test;

  localparam int PROG_CYCLES  = 8;
  localparam int ERASE_CYCLES = 20;
  localparam int SUSP_CYCLES  = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [18:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [31:0] protBlk = 32'h8000_0000;
  logic        idSel = 1'b0;
  logic [1:0]  rdSel;
  logic [7:0]  statusByte;
  logic [15:0] idWord;
  logic [15:0] cfgOut;
  logic        opStart, opErase, opSuspend;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES),
                   .SUSP_CYCLES(SUSP_CYCLES), .TOP_BOOT(1'b1)) uut (
    .clk, .rstN, .wrEn, .wrAddr, .wrData, .protBlk, .idSel,
    .rdSel, .statusByte, .idWord, .cfgOut, .opStart, .opErase, .opSuspend
  );

  typedef struct packed {
    logic [18:0] addr;
    logic [7:0]  data;
    logic [1:0]  sel;
    logic [7:0]  stat;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VECS [NVEC] = '{
    '{19'h00000, 8'hFF, 2'd0, 8'h80},  // R2 array
    '{19'h00000, 8'h90, 2'd1, 8'h80},  // R2 identification
    '{19'h00000, 8'h98, 2'd2, 8'h80},  // R2 query
    '{19'h00000, 8'h70, 2'd3, 8'h80},  // R2 status
    '{19'h00000, 8'hFF, 2'd0, 8'h80},  // R2 array again
    '{19'h00000, 8'hB0, 2'd0, 8'h80},  // R2 idle suspend ignored
    '{19'h00000, 8'hD0, 2'd0, 8'h80},  // R2 idle confirm ignored
    '{19'h00000, 8'h20, 2'd0, 8'h80},  // R5 erase setup
    '{19'h00100, 8'h55, 2'd3, 8'hB0},  // R5 bad confirm
    '{19'h00000, 8'h98, 2'd2, 8'hB0},  // R2 query, errors kept
    '{19'h00000, 8'h50, 2'd2, 8'h80},  // R10 clear keeps mode
    '{19'h00000, 8'h40, 2'd2, 8'h80},  // R6 program setup
    '{19'h7C010, 8'hAA, 2'd3, 8'h92},  // R6 program to locked block
    '{19'h00000, 8'h50, 2'd3, 8'h80},  // R10 clear
    '{19'h00000, 8'h20, 2'd3, 8'h80},  // R6 erase setup
    '{19'h7FFFF, 8'hD0, 2'd3, 8'hA2},  // R6 erase to locked block
    '{19'h00000, 8'h50, 2'd3, 8'h80},  // R10 clear
    '{19'h00000, 8'h60, 2'd3, 8'h80},  // R11 config setup
    '{19'h01234, 8'h03, 2'd0, 8'h80}   // R11 config load
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic doWrite(input logic [18:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doWriteStrb(input logic [18:0] a, input logic [7:0] d,
                             input logic [2:0] expStrb, input string req);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    #1;
    chk(req, {29'd0, opStart, opErase, opSuspend}, {29'd0, expStrb});
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic countBusy(output int n);
    n = 0;
    while (!statusByte[7] && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdSel", 32'(rdSel), 32'd0);
    chk("R1 status", 32'(statusByte), 32'h80);
    chk("R1 cfg", 32'(cfgOut), 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      doWrite(VECS[i].addr, VECS[i].data);
      chk($sformatf("vector %0d rdSel", i), 32'(rdSel), 32'(VECS[i].sel));
      chk($sformatf("vector %0d status", i), 32'(statusByte), 32'(VECS[i].stat));
    end
    chk("R11 cfg loaded", 32'(cfgOut), 32'h1234);
    doWrite(19'h0, 8'h60);
    doWrite(19'h0ABCD, 8'h05);
    chk("R11 bad confirm cfg kept", 32'(cfgOut), 32'h1234);
    chk("R11 bad confirm rdSel", 32'(rdSel), 32'd0);

    // R4 program timing
    doWrite(19'h0, 8'h40);
    doWriteStrb(19'h00200, 8'h3C, 3'b100, "R4 start strobe");
    chk("R4 rdSel", 32'(rdSel), 32'd3);
    chk("R4 busy status", 32'(statusByte), 32'h00);
    countBusy(n);
    chk("R4 busy cycles", 32'(n), 32'(PROG_CYCLES));

    // R5, R8, R9 erase suspend and resume
    doWrite(19'h0, 8'h20);
    doWriteStrb(19'h04000, 8'hD0, 3'b110, "R5 erase strobe");
    doWriteStrb(19'h0, 8'hB0, 3'b001, "R8 suspend strobe");
    repeat (SUSP_CYCLES - 1) @(negedge clk);
    chk("R8 still halting", 32'(statusByte), 32'h00);
    @(negedge clk);
    chk("R8 erase paused", 32'(statusByte), 32'hC0);
    doWrite(19'h0, 8'hFF);
    chk("R9 array while paused", 32'(rdSel), 32'd0);
    doWrite(19'h0, 8'h70);
    chk("R9 status while paused", 32'(rdSel), 32'd3);
    doWrite(19'h0, 8'hD0);
    chk("R9 resumed status", 32'(statusByte), 32'h00);
    countBusy(n);
    chk("R9 remaining erase time", 32'(n), 32'(ERASE_CYCLES));

    // R7 writes ignored while busy
    doWrite(19'h0, 8'h20);
    doWrite(19'h08000, 8'hD0);
    doWrite(19'h0, 8'hFF);
    doWrite(19'h0, 8'h40);
    doWrite(19'h0, 8'h90);
    chk("R7 rdSel held", 32'(rdSel), 32'd3);
    countBusy(n);
    chk("R7 busy unaffected", 32'(n), 32'(ERASE_CYCLES - 3));
    doWrite(19'h0, 8'hFF);
    chk("R7 no pending program", 32'({rdSel, statusByte}), 32'({2'd0, 8'h80}));

    // R8, R3, R10 program suspend
    doWrite(19'h0, 8'h40);
    doWrite(19'h00300, 8'h11);
    doWriteStrb(19'h0, 8'hB0, 3'b001, "R8 program suspend strobe");
    repeat (SUSP_CYCLES) @(negedge clk);
    chk("R8 program paused", 32'(statusByte), 32'h84);
    doWrite(19'h0, 8'h90);
    chk("R3 ident mode", 32'(rdSel), 32'd1);
    idSel = 1'b0; #1;
    chk("R3 manufacturer", 32'(idWord), 32'h0020);
    idSel = 1'b1; #1;
    chk("R3 device", 32'(idWord), 32'h8836);
    @(negedge clk);
    doWrite(19'h0, 8'h50);
    chk("R10 clear while paused", 32'({rdSel, statusByte}), 32'({2'd1, 8'h84}));
    doWrite(19'h0, 8'hD0);
    chk("R9 program resumed", 32'({rdSel, statusByte}), 32'({2'd3, 8'h00}));
    countBusy(n);
    chk("R9 remaining program time", 32'(n), 32'(PROG_CYCLES));
    chk("R9 final status", 32'(statusByte), 32'h80);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule